// File: doc/BRIEF.md
# Local Interrupt Controller Base and Identity Registers

This block holds the identity and base-address state of one processor's local interrupt controller. A 64-bit base register carries the base address, an enable bit, a bootstrap-processor flag and an extended-mode bit. Around it sit an 8-bit legacy identifier, a 32-bit initial identifier taken from a strap, and five small local registers: task priority, spurious vector, logical destination, destination format and error status. A read-only flag records whether the processor has to wait for a startup message.

Two reset strobes act on the block. A full reset restores the base register and both identifiers, and also does everything an init reset does. An init reset only returns the local registers and the startup-wait flag to their start values. A separate designate input sets or clears the bootstrap flag. Setting the extended-mode bit through a base write makes the legacy identifier follow the initial identifier again. While extended mode is on, the identifier register reads back the full 32-bit initial identifier.

The register port has no handshake and no back-pressure. A write is always accepted and takes effect at the next clock edge. A read is combinational from the read address in the same cycle. Interrupt delivery and timers are outside this block.

Top module: `lic_ident_regs`

## Requirements
- R1: After power-on reset (rst_n low) the block holds these values. Base reads 0x0000_0000_FEE0_0800: default address 0xFEE00000 with the enable bit (bit 11) set, bootstrap flag (bit 8) clear and extended bit (bit 10) clear. The initial identifier is 0xFFFFFFFF and the legacy identifier is 0xFF. The local registers hold their init values and the startup-wait flag is 1.
- R2: A full reset sets the base register to 0xFEE00000 with bit 11 set and bit 10 clear, and keeps bit 8 at the value it had before the reset. A full reset wins over a base write in the same cycle.
- R3: A full reset loads the initial identifier from strap_id_i and the legacy identifier from strap_id_i[7:0], and in the same cycle performs every init-reset action (R8, R9).
- R4: A base write (address 0) stores bits 63:12, bit 11 and bit 10 of the write data. Bit 8 keeps its value, and every other low bit reads 0.
- R5: A base write that takes bit 10 from 0 to 1 reloads the legacy identifier from the low 8 bits of the initial identifier.
- R6: The identifier register is at address 1. With bit 10 set it reads the 32-bit initial identifier, zero-extended. With bit 10 clear it reads the legacy identifier in bits 7:0 and zeros above. A write to it updates the legacy identifier from bits 7:0 only when bit 10 is clear, and has no effect in extended mode.
- R7: The designate input (bsp_des_en_i) writes bsp_des_val_i into bit 8 only. It takes effect on top of a same-cycle base write or full reset.
- R8: An init reset sets task priority (address 3) to 0, spurious vector (4) to 0xFF, logical destination (5) to 0, destination format (6) to 0xF and error status (7) to 0. It wins over a same-cycle write to those registers.
- R9: The startup-wait flag is read at address 8, bit 0. An init or full reset sets it to the inverse of bit 8 as held before that cycle. Otherwise it holds, and writes to address 8 have no effect.
- R10: The version register at address 2 reads 0x14, and writes to it have no effect.
- R11: The task priority, spurious vector, logical destination and error status registers are 8 bits wide, and destination format is 4 bits. Written bits beyond a register's width are dropped. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| full_rst_i | input | 1 | Full reset strobe, one cycle |
| init_rst_i | input | 1 | Init reset strobe, one cycle |
| bsp_des_en_i | input | 1 | Bootstrap designate strobe |
| bsp_des_val_i | input | 1 | Bootstrap flag value to designate |
| strap_id_i | input | 32 | Initial identifier sampled on full reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 64 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 64 | Register read data, combinational |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. They check that the base register is rebuilt correctly after a full reset, that the identifiers reload from the strap and on an extended-mode rising edge, and that designate controls bit 8. They also check the local init values, the startup-wait flag after a reset and its stability otherwise, the version readback and the extended-mode identifier view. The bench scenarios are needed for the priority rules and for what a write leaves unchanged. That covers a reset against a same-cycle write, designate against a same-cycle full reset, identifier writes ignored in extended mode, masked bits of narrow registers, and writes to read-only addresses.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int DATA_W    = 64;
  localparam int ADDR_W    = 4;
  localparam int ID_W      = 32;
  localparam int LEG_W     = 8;
  localparam int FIELD_W   = 8;
  localparam int NUM_LOCAL = 5;

  localparam int BSP_BIT   = 8;
  localparam int EXT_BIT   = 10;
  localparam int EN_BIT    = 11;
  localparam int ADDR_LSB  = 12;

  localparam logic [63:0] BASE_DEFAULT = 64'h0000_0000_FEE0_0000;
  localparam logic [7:0]  VERSION_VAL  = 8'h14;

  typedef enum logic [3:0] {
    SEL_BASE  = 4'd0,
    SEL_ID    = 4'd1,
    SEL_VER   = 4'd2,
    SEL_TPR   = 4'd3,
    SEL_SPUR  = 4'd4,
    SEL_LDEST = 4'd5,
    SEL_DFMT  = 4'd6,
    SEL_ESR   = 4'd7,
    SEL_WAIT  = 4'd8
  } reg_sel_e;

  // local register i sits at address SEL_TPR + i
  function automatic int local_width(int i);
    case (i)
      3:       return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic [7:0] local_reset(int i);
    case (i)
      1:       return 8'hFF;
      3:       return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/lic_base_reg.sv
module lic_base_reg
  import lic_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         full_rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         des_en,
  input  logic         des_val,
  output logic [W-1:0] base_q,
  output logic         ext_rise
);
  localparam logic [W-1:0] ONE     = W'(1);
  localparam logic [W-1:0] BSP_M   = ONE << BSP_BIT;
  localparam logic [W-1:0] WMASK   = ~((ONE << ADDR_LSB) - ONE) | (ONE << EN_BIT) | (ONE << EXT_BIT);
  localparam logic [W-1:0] RST_VAL = W'(BASE_DEFAULT) | (ONE << EN_BIT);

  logic [W-1:0] nxt;

  assign ext_rise = wr & ~full_rst & wdata[EXT_BIT] & ~base_q[EXT_BIT];

  always_comb begin
    nxt = base_q;
    if (full_rst)
      nxt = RST_VAL | (base_q & BSP_M);
    else if (wr)
      nxt = (wdata & WMASK) | (base_q & BSP_M);
    if (des_en)
      nxt[BSP_BIT] = des_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= RST_VAL;
    else        base_q <= nxt;
  end
endmodule

// File: rtl/lic_id_regs.sv
module lic_id_regs
  import lic_pkg::*;
#(
  parameter int IW = ID_W,
  parameter int LW = LEG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_rst,
  input  logic [IW-1:0] strap,
  input  logic          ext_mode,
  input  logic          ext_rise,
  input  logic          id_wr,
  input  logic [LW-1:0] wr_leg,
  output logic [IW-1:0] init_q,
  output logic [LW-1:0] leg_q,
  output logic [IW-1:0] id_view
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '1;
      leg_q  <= '1;
    end else if (full_rst) begin
      init_q <= strap;
      leg_q  <= strap[LW-1:0];
    end else if (ext_rise) begin
      leg_q  <= init_q[LW-1:0];
    end else if (id_wr && !ext_mode) begin
      leg_q  <= wr_leg;
    end
  end

  assign id_view = ext_mode ? init_q : IW'(leg_q);
endmodule

// File: rtl/lic_local_regs.sv
module lic_local_regs
  import lic_pkg::*;
#(
  parameter int N  = NUM_LOCAL,
  parameter int FW = FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [N-1:0]         wr_vec,
  input  logic [FW-1:0]        wdata,
  input  logic                 bsp_now,
  output logic [N-1:0][FW-1:0] fields_q,
  output logic                 wait_q
);
  for (genvar g = 0; g < N; g++) begin : g_field
    localparam int            WID  = local_width(g);
    localparam logic [FW-1:0] MASK = FW'((64'd1 << WID) - 64'd1);
    localparam logic [FW-1:0] RST  = FW'(local_reset(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fields_q[g] <= RST;
      else if (clr)       fields_q[g] <= RST;
      else if (wr_vec[g]) fields_q[g] <= wdata & MASK;
    end
  end

  // power-on leaves the bootstrap flag clear, so the processor waits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wait_q <= 1'b1;
    else if (clr) wait_q <= ~bsp_now;
  end
endmodule

// File: rtl/lic_ident_regs.sv
module lic_ident_regs
  import lic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_rst_i,
  input  logic              init_rst_i,
  input  logic              bsp_des_en_i,
  input  logic              bsp_des_val_i,
  input  logic [ID_W-1:0]   strap_id_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0]                  base_q;
  logic                               ext_rise;
  logic [ID_W-1:0]                    init_id_q;
  logic [LEG_W-1:0]                   legacy_id_q;
  logic [ID_W-1:0]                    id_view;
  logic [NUM_LOCAL-1:0][FIELD_W-1:0]  fields_q;
  logic                               wait_q;
  logic [NUM_LOCAL-1:0]               wr_vec;
  logic                               wr_base;
  logic                               wr_id;

  assign wr_base = wr_en_i && (wr_addr_i == SEL_BASE);
  assign wr_id   = wr_en_i && (wr_addr_i == SEL_ID);

  always_comb begin
    for (int i = 0; i < NUM_LOCAL; i++)
      wr_vec[i] = wr_en_i && (wr_addr_i == ADDR_W'(int'(SEL_TPR) + i));
  end

  lic_base_reg #(.W(DATA_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .full_rst (full_rst_i),
    .wr       (wr_base),
    .wdata    (wr_data_i),
    .des_en   (bsp_des_en_i),
    .des_val  (bsp_des_val_i),
    .base_q   (base_q),
    .ext_rise (ext_rise)
  );

  lic_id_regs #(.IW(ID_W), .LW(LEG_W)) u_id (
    .clk      (clk),
    .rst_n    (rst_n),
    .full_rst (full_rst_i),
    .strap    (strap_id_i),
    .ext_mode (base_q[EXT_BIT]),
    .ext_rise (ext_rise),
    .id_wr    (wr_id),
    .wr_leg   (wr_data_i[LEG_W-1:0]),
    .init_q   (init_id_q),
    .leg_q    (legacy_id_q),
    .id_view  (id_view)
  );

  lic_local_regs #(.N(NUM_LOCAL), .FW(FIELD_W)) u_local (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (full_rst_i | init_rst_i),
    .wr_vec   (wr_vec),
    .wdata    (wr_data_i[FIELD_W-1:0]),
    .bsp_now  (base_q[BSP_BIT]),
    .fields_q (fields_q),
    .wait_q   (wait_q)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      SEL_BASE: rd_data_o = base_q;
      SEL_ID:   rd_data_o = DATA_W'(id_view);
      SEL_VER:  rd_data_o = DATA_W'(VERSION_VAL);
      SEL_WAIT: rd_data_o = DATA_W'(wait_q);
      default: begin
        for (int i = 0; i < NUM_LOCAL; i++)
          if (rd_addr_i == ADDR_W'(int'(SEL_TPR) + i))
            rd_data_o = DATA_W'(fields_q[i]);
      end
    endcase
  end
endmodule

// File: rtl/lic_ident_regs_chk.sv
module lic_ident_regs_chk
  import lic_pkg::*;
(
  input logic                              clk,
  input logic                              rst_n,
  input logic                              full_rst_i,
  input logic                              init_rst_i,
  input logic                              bsp_des_en_i,
  input logic                              bsp_des_val_i,
  input logic [ID_W-1:0]                   strap_id_i,
  input logic                              wr_en_i,
  input logic [ADDR_W-1:0]                 wr_addr_i,
  input logic [DATA_W-1:0]                 wr_data_i,
  input logic [ADDR_W-1:0]                 rd_addr_i,
  input logic [DATA_W-1:0]                 rd_data_o,
  input logic [DATA_W-1:0]                 base_q,
  input logic [ID_W-1:0]                   init_id_q,
  input logic [LEG_W-1:0]                  legacy_id_q,
  input logic [NUM_LOCAL-1:0][FIELD_W-1:0] fields_q,
  input logic                              wait_q
);
  a_r2_full_reset_base: assert property (@(posedge clk) disable iff (!rst_n)
    (full_rst_i && !bsp_des_en_i) |=>
      base_q == (64'h0000_0000_FEE0_0800 | (64'($past(base_q[BSP_BIT])) << BSP_BIT)));

  a_r3_full_reset_ids: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst_i |=> (init_id_q == $past(strap_id_i)) && (legacy_id_q == $past(strap_id_i[7:0])));

  a_r5_ext_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_rst_i && wr_en_i && wr_addr_i == SEL_BASE && wr_data_i[EXT_BIT] && !base_q[EXT_BIT])
      |=> legacy_id_q == $past(init_id_q[7:0]));

  a_r6_ext_id_view: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q[EXT_BIT] && rd_addr_i == SEL_ID) |-> rd_data_o == 64'(init_id_q));

  a_r7_designate: assert property (@(posedge clk) disable iff (!rst_n)
    bsp_des_en_i |=> base_q[BSP_BIT] == $past(bsp_des_val_i));

  a_r8_init_values: assert property (@(posedge clk) disable iff (!rst_n)
    (init_rst_i || full_rst_i) |=>
      (fields_q[0] == 8'h00) && (fields_q[1] == 8'hFF) && (fields_q[2] == 8'h00) &&
      (fields_q[3] == 8'h0F) && (fields_q[4] == 8'h00));

  a_r9_wait_set: assert property (@(posedge clk) disable iff (!rst_n)
    (init_rst_i || full_rst_i) |=> wait_q == !$past(base_q[BSP_BIT]));

  a_r9_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_rst_i || full_rst_i) |=> $stable(wait_q));

  a_r10_version: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == SEL_VER) |-> rd_data_o == 64'h14);
endmodule

bind lic_ident_regs lic_ident_regs_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .full_rst_i    (full_rst_i),
  .init_rst_i    (init_rst_i),
  .bsp_des_en_i  (bsp_des_en_i),
  .bsp_des_val_i (bsp_des_val_i),
  .strap_id_i    (strap_id_i),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o),
  .base_q        (base_q),
  .init_id_q     (init_id_q),
  .legacy_id_q   (legacy_id_q),
  .fields_q      (fields_q),
  .wait_q        (wait_q)
);

// File: tb/tb_lic_ident_regs.sv
module tb_lic_ident_regs;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        full_rst_i, init_rst_i, bsp_des_en_i, bsp_des_val_i;
  logic [31:0] strap_id_i;
  logic        wr_en_i;
  logic [3:0]  wr_addr_i, rd_addr_i;
  logic [63:0] wr_data_i, rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model, written from the requirements
  logic [63:0] m_base;
  logic [31:0] m_init;
  logic [7:0]  m_leg;
  logic [7:0]  m_loc [5];
  logic        m_wait;

  always #(CLK_P/2) clk = ~clk;

  lic_ident_regs dut (
    .clk(clk), .rst_n(rst_n), .full_rst_i(full_rst_i), .init_rst_i(init_rst_i),
    .bsp_des_en_i(bsp_des_en_i), .bsp_des_val_i(bsp_des_val_i), .strap_id_i(strap_id_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [7:0] loc_init(int i);
    return (i == 1) ? 8'hFF : (i == 3) ? 8'h0F : 8'h00;
  endfunction

  function automatic logic [7:0] loc_mask(int i);
    return (i == 3) ? 8'h0F : 8'hFF;
  endfunction

  function automatic logic [63:0] exp_read(logic [3:0] a);
    case (a)
      4'd0: return m_base;
      4'd1: return m_base[10] ? {32'd0, m_init} : {56'd0, m_leg};
      4'd2: return 64'h14;
      4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return {56'd0, m_loc[a - 4'd3]};
      4'd8: return {63'd0, m_wait};
      default: return 64'd0;
    endcase
  endfunction

  task automatic model_por();
    m_base = 64'hFEE0_0800;
    m_init = 32'hFFFF_FFFF;
    m_leg  = 8'hFF;
    for (int i = 0; i < 5; i++) m_loc[i] = loc_init(i);
    m_wait = 1'b1;
  endtask

  // one clock step: drive at the falling edge, model the rising edge
  task automatic step(input bit f, input bit ir, input bit de, input bit dv,
                      input bit w, input logic [3:0] wa, input logic [63:0] wd,
                      input logic [31:0] st);
    logic [63:0] nb;
    logic [31:0] ni;
    logic [7:0]  nl;
    @(negedge clk);
    full_rst_i = f; init_rst_i = ir; bsp_des_en_i = de; bsp_des_val_i = dv;
    wr_en_i = w; wr_addr_i = wa; wr_data_i = wd; strap_id_i = st;
    nb = m_base; ni = m_init; nl = m_leg;
    if (f) begin
      nb = 64'hFEE0_0800 | (m_base & 64'h100);
      ni = st;
      nl = st[7:0];
    end else if (w && wa == 4'd0) begin
      if (wd[10] && !m_base[10]) nl = m_init[7:0];
      nb = (wd & 64'hFFFF_FFFF_FFFF_FC00 & ~64'h300) | (m_base & 64'h100);
    end else if (w && wa == 4'd1 && !m_base[10]) begin
      nl = wd[7:0];
    end
    if (de) nb[8] = dv;
    @(posedge clk);
    #1;
    if (f || ir) begin
      for (int i = 0; i < 5; i++) m_loc[i] = loc_init(i);
      m_wait = ~m_base[8];
    end else if (w && wa >= 4'd3 && wa <= 4'd7) begin
      m_loc[wa - 4'd3] = wd[7:0] & loc_mask(int'(wa) - 3);
    end
    m_base = nb; m_init = ni; m_leg = nl;
    full_rst_i = 0; init_rst_i = 0; bsp_des_en_i = 0; wr_en_i = 0;
  endtask

  task automatic check_reg(input logic [3:0] a, input string tag);
    logic [63:0] e;
    @(negedge clk);
    rd_addr_i = a;
    #1;
    e = exp_read(a);
    checks++;
    if (rd_data_o !== e) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data_o, e);
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 16; a++) check_reg(4'(a), tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; full_rst_i = 0; init_rst_i = 0; bsp_des_en_i = 0; bsp_des_val_i = 0;
    strap_id_i = 0; wr_en_i = 0; wr_addr_i = 0; wr_data_i = 0; rd_addr_i = 0;
    model_por();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    check_all("R1");                                              // power-on state
    step(0,0,0,0, 1, 4'd0, 64'h1234_5678_9ABC_D3FF, 0);
    check_reg(4'd0, "R4");                                        // base write masking
    step(0,0,0,0, 1, 4'd1, 64'hFFFF_FFFF_FFFF_FF5A, 0);
    check_reg(4'd1, "R6");                                        // legacy id write
    step(1,0,0,0, 0, 0, 0, 32'hA5C3_0177);
    check_reg(4'd1, "R3");
    step(0,0,0,0, 1, 4'd1, 64'h22, 0);
    step(0,0,0,0, 1, 4'd0, 64'hFEE0_0400, 0);                     // extended on
    check_reg(4'd1, "R5");
    check_reg(4'd1, "R6");
    step(0,0,0,0, 1, 4'd1, 64'h99, 0);                            // ignored in extended
    check_reg(4'd1, "R6");
    step(0,0,0,0, 1, 4'd0, 64'hFEE0_0000, 0);
    check_reg(4'd1, "R5");
    step(0,0,1,1, 0, 0, 0, 0);
    check_reg(4'd0, "R7");
    step(1,0,0,0, 1, 4'd0, 64'hFFFF_0000_0000_0400, 32'h0000_0042); // reset beats write
    check_reg(4'd0, "R2");
    check_reg(4'd8, "R9");
    step(0,0,0,0, 1, 4'd3, 64'hFFFF_FFFF_FFFF_FFAB, 0);
    step(0,0,0,0, 1, 4'd6, 64'hFF, 0);
    step(0,0,0,0, 1, 4'd4, 64'h0, 0);
    check_reg(4'd3, "R11");
    check_reg(4'd6, "R11");
    check_reg(4'd4, "R11");
    step(0,1,0,0, 1, 4'd5, 64'h77, 0);                            // init beats write
    check_reg(4'd3, "R8");
    check_reg(4'd4, "R8");
    check_reg(4'd5, "R8");
    check_reg(4'd6, "R8");
    step(0,0,0,0, 1, 4'd2, 64'h55, 0);
    check_reg(4'd2, "R10");
    step(0,0,0,0, 1, 4'd8, 64'h1, 0);
    check_reg(4'd8, "R9");
    step(1,0,1,0, 0, 0, 0, 32'h0000_0011);                        // designate on top of reset
    check_reg(4'd0, "R7");
    step(0,1,0,0, 0, 0, 0, 0);
    check_reg(4'd8, "R9");
    check_reg(4'd12, "R11");

    for (int n = 0; n < 400; n++) begin
      int op;
      logic [63:0] d;
      op = int'($urandom % 10);
      d  = {$urandom, $urandom};
      if ($urandom % 3 == 0) d[10] = ~d[10];
      step(op == 0, op == 1, ($urandom % 5) == 0, 1'($urandom),
           op >= 2, 4'($urandom % 10), d, $urandom);
      if (n % 20 == 0) check_all("RAND");
      else check_reg(4'($urandom % 10), "RAND");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule